// File: doc/BRIEF.md
# Load/Store Pipeline Progress Tracker

This block follows up to four in-flight memory instructions through a short in-order pipeline that ends in a store buffer. Each tracked instruction is a load or a store, has an in-order id equal to its slot index, and carries a small table of (stage, cycle-count) pairs that say how long it waits in a given stage. On every clock the block moves each instruction forward by at most one stage, or counts down its remaining wait. The bus-grant input gates the countdown of loads in the load-unit stage, and the store buffer's occupancy gates the retirement of stores.

Software or a surrounding model programs all slots at once by pulsing a configuration strobe, which also restarts the run. The outputs show, for every slot, its stage code and remaining count, together with the id that may issue next and the store buffer's fill state. The block holds no data, addresses or cache contents. It models timing and ordering only.

Top module: `lsq_pipe_tracker`

## Requirements
- R1: While rst_n is low at a clock edge, or cfg_load is high at a clock edge, every slot goes to pre-issue (code 0) with count 0, next_id goes to 0 and sb_state goes to Empty (0). A cfg_load edge also captures the per-slot kind and latency tables.
- R2: Stage codes are pre-issue 0, shared 1, load-unit 2, store-unit 3 and done 4. With a zero count, a shared-stage load moves to load-unit and a shared-stage store moves to store-unit. A load-unit instruction moves to done, and done never changes.
- R3: Slot i leaves pre-issue only on an edge where next_id equals i and no slot is in the shared stage. On that edge next_id increments by one. Otherwise next_id holds.
- R4: On entering a stage, the count takes the value of the lowest-indexed table entry whose 3-bit stage field matches that stage, or 0 if no entry matches. Only the shared and load-unit stages take a nonzero value, so entries naming pre-issue, store-unit or done load 0.
- R5: A nonzero count in the shared stage drops by one on every edge. An instruction changes stage only on an edge where its count is 0.
- R6: A nonzero count in the load-unit stage drops by one only on edges where bus_taken is high and holds otherwise. A load-unit instruction with count 0 moves to done whatever bus_taken is.
- R7: A store-unit instruction moves to done only on an edge where sb_state is not Full. At most one store retires per edge, and the lowest-indexed waiting slot goes first.
- R8: Buffer occupancy counts retired stores up to SB_DEPTH. sb_drain removes one entry per edge when occupancy is nonzero and has no effect when it is zero. A retire and a drain on the same edge leave occupancy unchanged. sb_state is Empty (0) at zero, Full (2) at SB_DEPTH and NotEmpty (1) between.
- R9: Consider two runs from the same configuration, where the second run's bus_taken is high at least whenever the first run's is. At every edge, each slot in the second run is at least as far advanced. A later stage counts as further (pre-issue < shared < load-unit/store-unit < done), and within the same stage a smaller count counts as further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Restart and capture slot configuration |
| cfg_is_store | input | NUM_SLOTS | Per-slot kind, 1 = store |
| cfg_tbl_stage | input | NUM_SLOTS*LAT_ENTRIES*3 | Stage field of each latency entry, slot-major |
| cfg_tbl_count | input | NUM_SLOTS*LAT_ENTRIES*CNT_W | Count field of each latency entry, slot-major |
| bus_taken | input | 1 | Bus grant, enables load-unit countdown |
| sb_drain | input | 1 | Remove one store buffer entry |
| slot_stage | output | NUM_SLOTS*3 | Stage code per slot, slot 0 in low bits |
| slot_count | output | NUM_SLOTS*CNT_W | Remaining count per slot |
| next_id | output | $clog2(NUM_SLOTS+1) | Id allowed to leave pre-issue next |
| sb_state | output | 2 | Store buffer state: 0 Empty, 1 NotEmpty, 2 Full |

## Verification
Several corner cases are targeted. A load held in the load-unit stage while the bus is idle must keep its count; a design that counted down regardless would finish loads early. A table with two entries for the same stage must use the first, and a store whose table names the store-unit stage must still take zero. The bench fills the buffer with waiting stores and then drains one entry. A design without retire priority would push two stores into one free entry and overflow, and a design that let drain and retire cancel wrongly would show the wrong fill state. A final pair of runs with a denser bus grant in the second confirms that no slot ever falls behind; a design whose shared-stage issue depended on the bus would break this ordering.

// File: rtl/lsq_pkg.sv
// Package: shared stage and buffer-state encodings for the pipeline tracker.
// Assumes stage codes are fixed; neighbours decode them from slot_stage.
package lsq_pkg;

    typedef enum logic [2:0] {
        STG_PRE  = 3'd0,
        STG_SHR  = 3'd1,
        STG_LDU  = 3'd2,
        STG_STU  = 3'd3,
        STG_DONE = 3'd4
    } stage_e;

    typedef enum logic [1:0] {
        SB_EMPTY   = 2'd0,
        SB_PARTIAL = 2'd1,
        SB_FULL    = 2'd2
    } sb_state_e;

    // True for stages that are allowed to hold a nonzero wait count.
    function automatic logic stage_has_wait(input stage_e s);
        return (s == STG_SHR) || (s == STG_LDU);
    endfunction

endpackage

// File: rtl/lsq_lat_lookup.sv
// Module: first-match search of one slot's latency table for a target stage.
// Assumes entry k occupies bits [k*3 +: 3] / [k*CNT_W +: CNT_W]; returns 0
// when nothing matches or the stage may not wait.
module lsq_lat_lookup
    import lsq_pkg::*;
#(
    parameter int LAT_ENTRIES = 2,
    parameter int CNT_W       = 4
) (
    input  logic [LAT_ENTRIES*3-1:0]     tbl_stage,
    input  logic [LAT_ENTRIES*CNT_W-1:0] tbl_count,
    input  stage_e                       query,
    output logic [CNT_W-1:0]             wait_cnt
);

    // Scan from the top entry down so the lowest matching index wins.
    always_comb begin
        wait_cnt = '0;
        for (int k = LAT_ENTRIES - 1; k >= 0; k--) begin
            if (tbl_stage[k*3 +: 3] == query) begin
                wait_cnt = tbl_count[k*CNT_W +: CNT_W];
            end
        end
        if (!stage_has_wait(query)) begin
            wait_cnt = '0;
        end
    end

endmodule

// File: rtl/lsq_slot.sv
// Module: state of one tracked instruction (stage and remaining count).
// Assumes its id equals SLOT_ID, that the top grants at most one store
// retirement per cycle, and that restart has priority over all movement.
module lsq_slot
    import lsq_pkg::*;
#(
    parameter int SLOT_ID     = 0,
    parameter int LAT_ENTRIES = 2,
    parameter int CNT_W       = 4,
    parameter int ID_W        = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         restart,
    input  logic                         cfg_store,
    input  logic [LAT_ENTRIES*3-1:0]     cfg_stage,
    input  logic [LAT_ENTRIES*CNT_W-1:0] cfg_count,
    input  logic [ID_W-1:0]              next_id,
    input  logic                         shared_free,
    input  logic                         bus_taken,
    input  logic                         retire_grant,
    output stage_e                       stage_o,
    output logic [CNT_W-1:0]             count_o,
    output logic                         issue_o,
    output logic                         retire_req_o
);

    localparam int TBL_SW = LAT_ENTRIES * 3;
    localparam int TBL_CW = LAT_ENTRIES * CNT_W;

    logic              is_store_q;
    logic [TBL_SW-1:0] tbl_stage_q;
    logic [TBL_CW-1:0] tbl_count_q;
    stage_e            stage_q, stage_d, dest;
    logic [CNT_W-1:0]  count_q, count_d, entry_cnt;
    logic              move;

    lsq_lat_lookup #(
        .LAT_ENTRIES(LAT_ENTRIES),
        .CNT_W      (CNT_W)
    ) i_lookup (
        .tbl_stage(tbl_stage_q),
        .tbl_count(tbl_count_q),
        .query    (dest),
        .wait_cnt (entry_cnt)
    );

    // Capture kind and latency table on restart; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_store_q  <= 1'b0;
            tbl_stage_q <= '0;
            tbl_count_q <= '0;
        end else if (restart) begin
            is_store_q  <= cfg_store;
            tbl_stage_q <= cfg_stage;
            tbl_count_q <= cfg_count;
        end
    end

    // Decide whether the slot moves this cycle, where, and its next count.
    always_comb begin
        issue_o      = (stage_q == STG_PRE) && (next_id == ID_W'(SLOT_ID)) && shared_free;
        retire_req_o = (stage_q == STG_STU) && (count_q == '0);
        move         = 1'b0;
        dest         = stage_q;
        if (count_q == '0) begin
            case (stage_q)
                STG_PRE: begin move = issue_o;      dest = STG_SHR;  end
                STG_SHR: begin move = 1'b1;         dest = is_store_q ? STG_STU : STG_LDU; end
                STG_LDU: begin move = 1'b1;         dest = STG_DONE; end
                STG_STU: begin move = retire_grant; dest = STG_DONE; end
                default: begin move = 1'b0;         dest = stage_q;  end
            endcase
        end
        stage_d = move ? dest : stage_q;
        if (move) begin
            count_d = entry_cnt;
        end else if ((count_q != '0) && ((stage_q != STG_LDU) || bus_taken)) begin
            count_d = count_q - 1'b1;
        end else begin
            count_d = count_q;
        end
    end

    // Slot state register with reset and restart to pre-issue.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            stage_q <= STG_PRE;
            count_q <= '0;
        end else begin
            stage_q <= stage_d;
            count_q <= count_d;
        end
    end

    assign stage_o = stage_q;
    assign count_o = count_q;

    assert_stu_zero_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == STG_STU) |-> (count_q == '0));

    assert_ldu_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && stage_q == STG_LDU && count_q != '0 && !bus_taken)
        |=> (stage_q == STG_LDU && count_q == $past(count_q)));

    assert_shr_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && stage_q == STG_SHR && count_q != '0)
        |=> (stage_q == STG_SHR && count_q == CNT_W'($past(count_q) - 1'b1)));

    assert_done_terminal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && stage_q == STG_DONE) |=> (stage_q == STG_DONE));

endmodule

// File: rtl/lsq_sb_occ.sv
// Module: store buffer occupancy counter and its three-valued state.
// Assumes push is never raised while full and at most one push per cycle.
module lsq_sb_occ
    import lsq_pkg::*;
#(
    parameter int SB_DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      push,
    input  logic      drain,
    output sb_state_e state_o,
    output logic      full_o
);

    localparam int OCC_W = $clog2(SB_DEPTH + 1);

    logic [OCC_W-1:0] occ_q, occ_d;
    logic             pop;

    // Next occupancy: add a retired store, remove a drained entry.
    always_comb begin
        pop   = drain && (occ_q != '0);
        occ_d = occ_q + OCC_W'(push) - OCC_W'(pop);
    end

    // Occupancy register with reset and restart to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_d;
        end
    end

    // Map occupancy onto the reported buffer state.
    always_comb begin
        full_o = (occ_q == OCC_W'(SB_DEPTH));
        if (occ_q == '0) begin
            state_o = SB_EMPTY;
        end else if (full_o) begin
            state_o = SB_FULL;
        end else begin
            state_o = SB_PARTIAL;
        end
    end

    assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(SB_DEPTH));

    assert_push_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !push);

endmodule

// File: rtl/lsq_pipe_tracker.sv
// Module: top of the load/store pipeline tracker. Instantiates one slot per
// tracked instruction, arbitrates store retirement and keeps the issue id.
// Assumes slot i holds instruction id i and that ids issue in order.
module lsq_pipe_tracker
    import lsq_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int LAT_ENTRIES = 2,
    parameter int CNT_W       = 4,
    parameter int SB_DEPTH    = 2,
    localparam int ID_W       = $clog2(NUM_SLOTS + 1)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_load,
    input  logic [NUM_SLOTS-1:0]                   cfg_is_store,
    input  logic [NUM_SLOTS*LAT_ENTRIES*3-1:0]     cfg_tbl_stage,
    input  logic [NUM_SLOTS*LAT_ENTRIES*CNT_W-1:0] cfg_tbl_count,
    input  logic                                   bus_taken,
    input  logic                                   sb_drain,
    output logic [NUM_SLOTS*3-1:0]                 slot_stage,
    output logic [NUM_SLOTS*CNT_W-1:0]             slot_count,
    output logic [ID_W-1:0]                        next_id,
    output logic [1:0]                             sb_state
);

    localparam int TBL_SW = LAT_ENTRIES * 3;
    localparam int TBL_CW = LAT_ENTRIES * CNT_W;

    stage_e                 stg [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]   in_shared, issue, retire_req, grant;
    logic                   shared_free, sb_full;
    logic [ID_W-1:0]        next_id_q;
    sb_state_e              sb_st;

    assign shared_free = ~|in_shared;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        lsq_slot #(
            .SLOT_ID    (i),
            .LAT_ENTRIES(LAT_ENTRIES),
            .CNT_W      (CNT_W),
            .ID_W       (ID_W)
        ) i_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .restart     (cfg_load),
            .cfg_store   (cfg_is_store[i]),
            .cfg_stage   (cfg_tbl_stage[i*TBL_SW +: TBL_SW]),
            .cfg_count   (cfg_tbl_count[i*TBL_CW +: TBL_CW]),
            .next_id     (next_id_q),
            .shared_free (shared_free),
            .bus_taken   (bus_taken),
            .retire_grant(grant[i]),
            .stage_o     (stg[i]),
            .count_o     (slot_count[i*CNT_W +: CNT_W]),
            .issue_o     (issue[i]),
            .retire_req_o(retire_req[i])
        );
        assign in_shared[i]        = (stg[i] == STG_SHR);
        assign slot_stage[i*3 +: 3] = stg[i];
    end

    // Grant one retirement per cycle to the lowest waiting store, if room.
    always_comb begin
        logic taken;
        grant = '0;
        taken = sb_full;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (retire_req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    // Issue id counter: advances when a slot leaves pre-issue.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_load) begin
            next_id_q <= '0;
        end else if (|issue) begin
            next_id_q <= next_id_q + 1'b1;
        end
    end

    lsq_sb_occ #(
        .SB_DEPTH(SB_DEPTH)
    ) i_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(cfg_load),
        .push   (|grant),
        .drain  (sb_drain),
        .state_o(sb_st),
        .full_o (sb_full)
    );

    assign next_id  = next_id_q;
    assign sb_state = sb_st;

    assert_single_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_shared) <= 1);

    assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue));

    assert_id_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> (next_id_q == $past(next_id_q)) ||
                      (next_id_q == ID_W'($past(next_id_q) + 1'b1)));

    assert_one_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

// File: tb/test_lsq_pipe_tracker.sv
`timescale 1ns/100ps
// Bench: table-driven run of a mixed load/store sequence, then directed
// tests for reset, buffer back-pressure and bus-grant monotonicity.
module test_lsq_pipe_tracker;

    localparam int N  = 4;
    localparam int E  = 2;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst_n, cfg_load, bus_taken, sb_drain;
    logic [N-1:0]    cfg_is_store;
    logic [N*E*3-1:0]  cfg_tbl_stage;
    logic [N*E*CW-1:0] cfg_tbl_count;
    logic [N*3-1:0]  slot_stage;
    logic [N*CW-1:0] slot_count;
    logic [2:0]      next_id;
    logic [1:0]      sb_state;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    lsq_pipe_tracker i_lsq_pipe_tracker (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_is_store(cfg_is_store),
        .cfg_tbl_stage(cfg_tbl_stage), .cfg_tbl_count(cfg_tbl_count),
        .bus_taken(bus_taken), .sb_drain(sb_drain), .slot_stage(slot_stage),
        .slot_count(slot_count), .next_id(next_id), .sb_state(sb_state)
    );

    typedef struct packed {
        logic        bus;
        logic        drain;
        logic [11:0] stg;
        logic [15:0] cnt;
        logic [2:0]  nid;
        logic [1:0]  sb;
    } vec_t;

    // Rows for the mixed sequence: inputs before an edge, outputs after it.
    localparam vec_t VEC [12] = '{
        '{1'b0, 1'b0, {3'd0, 3'd0, 3'd0, 3'd1}, 16'h0001, 3'd1, 2'd0},
        '{1'b0, 1'b0, {3'd0, 3'd0, 3'd0, 3'd1}, 16'h0000, 3'd1, 2'd0},
        '{1'b0, 1'b0, {3'd0, 3'd0, 3'd0, 3'd2}, 16'h0002, 3'd1, 2'd0},
        '{1'b0, 1'b0, {3'd0, 3'd0, 3'd1, 3'd2}, 16'h0002, 3'd2, 2'd0},
        '{1'b1, 1'b0, {3'd0, 3'd0, 3'd3, 3'd2}, 16'h0001, 3'd2, 2'd0},
        '{1'b0, 1'b0, {3'd0, 3'd1, 3'd4, 3'd2}, 16'h0001, 3'd3, 2'd1},
        '{1'b1, 1'b0, {3'd0, 3'd2, 3'd4, 3'd2}, 16'h0100, 3'd3, 2'd1},
        '{1'b0, 1'b0, {3'd1, 3'd2, 3'd4, 3'd4}, 16'h0100, 3'd4, 2'd1},
        '{1'b0, 1'b1, {3'd3, 3'd2, 3'd4, 3'd4}, 16'h0100, 3'd4, 2'd0},
        '{1'b1, 1'b0, {3'd4, 3'd2, 3'd4, 3'd4}, 16'h0000, 3'd4, 2'd1},
        '{1'b0, 1'b0, {3'd4, 3'd4, 3'd4, 3'd4}, 16'h0000, 3'd4, 2'd1},
        '{1'b0, 1'b1, {3'd4, 3'd4, 3'd4, 3'd4}, 16'h0000, 3'd4, 2'd0}
    };

    logic [2:0] st_a [40][N];
    logic [3:0] ct_a [40][N];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic b, input logic d);
        bus_taken = b;
        sb_drain  = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_entry(input int s, input int e, input logic [2:0] st, input logic [3:0] c);
        cfg_tbl_stage[(s*E+e)*3 +: 3]   = st;
        cfg_tbl_count[(s*E+e)*CW +: CW] = c;
    endtask

    task automatic restart_run();
        cfg_load = 1'b1;
        step(1'b0, 1'b0);
        cfg_load = 1'b0;
    endtask

    function automatic int rank(input logic [2:0] s);
        case (s)
            3'd0: return 0;
            3'd1: return 1;
            3'd2, 3'd3: return 2;
            default: return 3;
        endcase
    endfunction

    task automatic final_summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired before the run ended");
        final_summary();
    end

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0; bus_taken = 1'b0; sb_drain = 1'b0;
        cfg_is_store = '0; cfg_tbl_stage = '0; cfg_tbl_count = '0;
        @(negedge clk);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        // R1: reset state at the ports
        check("R1 reset stages", 32'(slot_stage), 32'h0);
        check("R1 reset counts", 32'(slot_count), 32'h0);
        check("R1 reset next_id", 32'(next_id), 32'd0);
        check("R1 reset sb_state", 32'(sb_state), 32'd0);
        rst_n = 1'b1;

        // Mixed sequence: R2 routing, R4 first match, R5, R6, R7, R8.
        cfg_is_store = 4'b1010;
        set_entry(0, 0, 3'd1, 4'd1); set_entry(0, 1, 3'd2, 4'd2);
        set_entry(1, 0, 3'd4, 4'd9); set_entry(1, 1, 3'd4, 4'd9);
        set_entry(2, 0, 3'd2, 4'd1); set_entry(2, 1, 3'd2, 4'd3);
        set_entry(3, 0, 3'd3, 4'd5); set_entry(3, 1, 3'd0, 4'd7);
        restart_run();
        for (int r = 0; r < 12; r++) begin
            step(VEC[r].bus, VEC[r].drain);
            check($sformatf("R2/R3/R6 row %0d stages", r), 32'(slot_stage), 32'(VEC[r].stg));
            check($sformatf("R4/R5/R6 row %0d counts", r), 32'(slot_count), 32'(VEC[r].cnt));
            check($sformatf("R3 row %0d next_id", r), 32'(next_id), 32'(VEC[r].nid));
            check($sformatf("R7/R8 row %0d sb_state", r), 32'(sb_state), 32'(VEC[r].sb));
        end

        // Back-pressure: four zero-wait stores, buffer depth 2, no drain.
        cfg_is_store = 4'b1111;
        cfg_tbl_stage = '0; cfg_tbl_count = '0;
        restart_run();
        for (int c = 0; c < 9; c++) step(1'b0, 1'b0);
        check("R7 stores blocked while full", 32'(slot_stage), 32'({3'd3, 3'd3, 3'd4, 3'd4}));
        check("R8 full state", 32'(sb_state), 32'd2);
        step(1'b0, 1'b1);
        check("R7 no retire on the full edge", 32'(slot_stage), 32'({3'd3, 3'd3, 3'd4, 3'd4}));
        check("R8 drain one entry", 32'(sb_state), 32'd1);
        step(1'b0, 1'b0);
        check("R7 lowest slot retires alone", 32'(slot_stage), 32'({3'd3, 3'd4, 3'd4, 3'd4}));
        check("R8 refilled", 32'(sb_state), 32'd2);
        step(1'b0, 1'b1);
        check("R8 drain from full", 32'(sb_state), 32'd1);
        step(1'b0, 1'b1);
        check("R7 last store retires", 32'(slot_stage), 32'({3'd4, 3'd4, 3'd4, 3'd4}));
        check("R8 retire plus drain holds", 32'(sb_state), 32'd1);
        step(1'b0, 1'b1);
        check("R8 drain to empty", 32'(sb_state), 32'd0);
        step(1'b0, 1'b1);
        check("R8 drain on empty ignored", 32'(sb_state), 32'd0);

        // Monotonicity under denser bus grant (R9).
        cfg_is_store = 4'b0100;
        set_entry(0, 0, 3'd1, 4'd2); set_entry(0, 1, 3'd2, 4'd3);
        set_entry(1, 0, 3'd2, 4'd2); set_entry(1, 1, 3'd1, 4'd1);
        set_entry(2, 0, 3'd1, 4'd1); set_entry(2, 1, 3'd3, 4'd0);
        set_entry(3, 0, 3'd2, 4'd4); set_entry(3, 1, 3'd2, 4'd1);
        restart_run();
        for (int c = 0; c < 40; c++) begin
            step((c % 3) == 0, 1'b0);
            for (int s = 0; s < N; s++) begin
                st_a[c][s] = slot_stage[s*3 +: 3];
                ct_a[c][s] = slot_count[s*CW +: CW];
            end
        end
        check("R9 first run completes", 32'(slot_stage), 32'({3'd4, 3'd4, 3'd4, 3'd4}));
        restart_run();
        // R1: restart clears a non-empty buffer and the id counter.
        check("R1 restart stages", 32'(slot_stage), 32'h0);
        check("R1 restart next_id", 32'(next_id), 32'd0);
        check("R1 restart sb_state", 32'(sb_state), 32'd0);
        for (int c = 0; c < 40; c++) begin
            step(((c % 3) == 0) || ((c % 2) == 0), 1'b0);
            for (int s = 0; s < N; s++) begin
                logic [2:0] sb_s;
                logic [3:0] cb;
                logic ok;
                sb_s = slot_stage[s*3 +: 3];
                cb   = slot_count[s*CW +: CW];
                ok   = (sb_s == st_a[c][s]) ? (cb <= ct_a[c][s])
                                            : (rank(sb_s) > rank(st_a[c][s]));
                check($sformatf("R9 cycle %0d slot %0d progress", c, s), 32'(ok), 32'd1);
            end
        end
        check("R9 second run completes", 32'(slot_stage), 32'({3'd4, 3'd4, 3'd4, 3'd4}));

        final_summary();
    end

endmodule